// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Buffer

This block recovers characters from an asynchronous serial line. A 16x oversampling clock enable paces all sampling; it can come from a receiver-only rate source that is separate from the transmit side. The line passes through a two-flop synchronizer. A state machine then finds the start bit, rejects start pulses that are too short, and collects 5 to 8 data bits, least significant first. It then checks an optional parity bit and the first stop bit.

Each finished character is written into a receive buffer together with a 3-bit error tag for parity, framing and break. With the buffer mode on, the buffer holds 16 characters. With it off, the buffer acts as a single holding register. A consumer reads the oldest entry from the head, pops it with a read strobe, and watches a data-ready flag, a sticky overrun flag and a receive interrupt request. Format settings are static inputs and change only while the line is idle.

The state machine has six states. RX_IDLE waits for a sampled low level, which is the start edge. RX_START confirms the start bit at tick 8 of 16; a high level there returns to RX_IDLE (false start). RX_DATA samples each data bit at tick 16 of its period and moves to RX_PARITY when parity is on, or to RX_STOP when it is off. RX_PARITY samples the parity bit and moves to RX_STOP. RX_STOP samples the stop bit and stores the character. It then goes back to RX_IDLE, or to RX_BRK_WAIT when a break was seen. RX_BRK_WAIT returns to RX_IDLE once the line is sampled high.

Top module: `async_rx`

## Requirements
- R1: `char_len` selects the character length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. Data bits above the character length read as zero in `rd_data`.
- R2: With `par_en` high, a parity bit follows the data. `par_odd`=0 selects even parity (data bits plus parity bit hold an even count of ones) and `par_odd`=1 selects odd parity. A mismatch sets `rd_err[0]` for that character.
- R3: Only the first stop bit is sampled. A low level there sets `rd_err[1]`. A start bit that follows a single stop bit directly is received as the next character.
- R4: A low pulse on the line that is already high again at tick 8 after the start edge stores nothing, and the receiver returns to idle.
- R5: A line that stays low through the start, data, parity and stop bits stores exactly one entry with data 0x00 and `rd_err`=3'b110 (break and framing set, parity clear). Nothing more is stored until the line has been sampled high.
- R6: With `fifo_mode`=1 the buffer holds up to 16 entries and returns them in arrival order, each with its own error tag.
- R7: A character that completes while the buffer is full is dropped and sets `overrun`. `overrun` stays high until the next pop.
- R8: With `fifo_mode`=0 the buffer holds one entry. A second character that arrives before a pop is an overrun.
- R9: Any change of `fifo_mode` empties the buffer and clears `overrun`.
- R10: `rx_irq` follows `data_ready` when `fifo_mode`=0. With `fifo_mode`=1 it is high when the buffer holds at least one entry and at least `irq_level` entries.
- R11: After reset `data_ready`, `overrun` and `rx_irq` are low.
- R12: `rd_en` on an empty buffer has no effect: the buffer stays empty and the next character is read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Character length code, 5 + value bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_mode | input | 1 | 1 = 16-entry buffer, 0 = single holding register |
| irq_level | input | 5 | Buffer fill level that raises `rx_irq` in buffer mode |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data |
| rd_err | output | 3 | Head entry tag: bit 2 break, bit 1 framing, bit 0 parity |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive data interrupt request |

## Verification
The hardest situations to reach from the ports are the ones that depend on where the line edges fall relative to the sample points. The stop-bit framing fault has to be held low past the stop sample but released before the receiver confirms a new start bit. Otherwise it turns into a false character. The bench therefore holds a bad stop bit low for ten ticks, so that the receiver sees the tail as a start pulse that is too short and rejects it. The break case needs a low line that lasts longer than a full character. It is sent with odd parity on, so that an all-zero frame would also fail parity, which shows that the break tag clears the parity flag. Overrun is reached by stopping the scoreboard's pops, filling the buffer with one framing-fault entry among the sixteen, and sending a seventeenth character.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_BRK_WAIT
    } rx_state_t;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_err_t;

    localparam int ERR_W  = $bits(rx_err_t);
    localparam int DATA_W = 8;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
    import async_rx_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output rx_err_t           push_err
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] MID_T  = CW'(TICKS / 2 - 1);
    localparam logic [CW-1:0] LAST_T = CW'(TICKS - 1);

    rx_state_t         state, nxt;
    logic [CW-1:0]     tcnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              all_zero;
    logic              smp_mid;
    logic              smp_full;
    logic [2:0]        last_idx;
    logic [DATA_W-1:0] char_word;
    logic              par_err;

    function automatic logic [DATA_W-1:0] align_char(input logic [DATA_W-1:0] sh,
                                                     input logic [1:0] len);
        logic [DATA_W-1:0] r;
        unique case (len)
            2'd0: r = {3'b000, sh[7:3]};
            2'd1: r = {2'b00,  sh[7:2]};
            2'd2: r = {1'b0,   sh[7:1]};
            default: r = sh;
        endcase
        return r;
    endfunction

    assign smp_mid   = tick && (tcnt == MID_T);
    assign smp_full  = tick && (tcnt == LAST_T);
    assign last_idx  = 3'd4 + {1'b0, char_len};
    assign char_word = align_char(shreg, char_len);
    assign par_err   = par_en && (((^char_word) ^ par_bit) != par_odd);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: begin
                if (tick && !rx_s) nxt = RX_START;
            end
            RX_START: begin
                if (smp_mid) nxt = rx_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (smp_full && (bit_idx == last_idx))
                    nxt = par_en ? RX_PARITY : RX_STOP;
            end
            RX_PARITY: begin
                if (smp_full) nxt = RX_STOP;
            end
            RX_STOP: begin
                if (smp_full) nxt = (!rx_s && all_zero) ? RX_BRK_WAIT : RX_IDLE;
            end
            RX_BRK_WAIT: begin
                if (tick && rx_s) nxt = RX_IDLE;
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // Bit timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            all_zero <= 1'b0;
        end else if (tick) begin
            if (nxt != state) tcnt <= '0;
            else if (tcnt == LAST_T) tcnt <= '0;
            else tcnt <= tcnt + 1'b1;

            if (state == RX_START && smp_mid) begin
                bit_idx  <= '0;
                shreg    <= '0;
                all_zero <= 1'b1;
            end
            if (state == RX_DATA && smp_full) begin
                bit_idx  <= bit_idx + 1'b1;
                shreg    <= {rx_s, shreg[DATA_W-1:1]};
                all_zero <= all_zero & ~rx_s;
            end
            if (state == RX_PARITY && smp_full) begin
                par_bit  <= rx_s;
                all_zero <= all_zero & ~rx_s;
            end
        end
    end

    // Outputs: one push per finished frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push      <= 1'b0;
            push_data <= '0;
            push_err  <= '0;
        end else begin
            push <= 1'b0;
            if (state == RX_STOP && smp_full) begin
                push <= 1'b1;
                if (!rx_s && all_zero) begin
                    push_data     <= '0;
                    push_err.brk  <= 1'b1;
                    push_err.ferr <= 1'b1;
                    push_err.perr <= 1'b0;
                end else begin
                    push_data     <= char_word;
                    push_err.brk  <= 1'b0;
                    push_err.ferr <= ~rx_s;
                    push_err.perr <= par_err;
                end
            end
        end
    end
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 11,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          mode_q;
    logic          flush;
    logic          wr_ok, rd_ok;

    assign flush = (fifo_mode != mode_q);
    assign empty = (level == '0);
    assign full  = fifo_mode ? (level == DEPTH_L) : !empty;
    assign wr_ok = wr && !full && !flush;
    assign rd_ok = rd && !empty && !flush;
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            wptr   <= '0;
            rptr   <= '0;
            level  <= '0;
            ovr    <= 1'b0;
        end else begin
            mode_q <= fifo_mode;
            if (flush) begin
                wptr  <= '0;
                rptr  <= '0;
                level <= '0;
                ovr   <= 1'b0;
            end else begin
                if (wr_ok) wptr <= (wptr == LAST_P) ? '0 : wptr + 1'b1;
                if (rd_ok) rptr <= (rptr == LAST_P) ? '0 : rptr + 1'b1;
                if (wr_ok && !rd_ok)      level <= level + 1'b1;
                else if (rd_ok && !wr_ok) level <= level - 1'b1;
                if (wr && full)  ovr <= 1'b1;
                else if (rd_ok)  ovr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TICKS = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              fifo_mode,
    input  logic [LW-1:0]     irq_level,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    output logic              data_ready,
    output logic              overrun,
    output logic              rx_irq
);
    localparam int ENT_W = DATA_W + ERR_W;

    logic              rx_s;
    logic              fsm_push;
    logic [DATA_W-1:0] fsm_data;
    rx_err_t           fsm_err;
    logic [ENT_W-1:0]  head;
    logic [LW-1:0]     level;
    logic              buf_full;
    logic              buf_empty;

    async_rx_sync #(.STAGES(2)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    async_rx_fsm #(.TICKS(TICKS)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx_s     (rx_s),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .push     (fsm_push),
        .push_data(fsm_data),
        .push_err (fsm_err)
    );

    async_rx_fifo #(.DEPTH(DEPTH), .W(ENT_W), .LW(LW)) i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_mode(fifo_mode),
        .wr       (fsm_push),
        .wdata    ({fsm_err, fsm_data}),
        .rd       (rd_en),
        .rdata    (head),
        .level    (level),
        .full     (buf_full),
        .empty    (buf_empty),
        .ovr      (overrun)
    );

    assign rd_data    = head[DATA_W-1:0];
    assign rd_err     = head[ENT_W-1:DATA_W];
    assign data_ready = !buf_empty;
    assign rx_irq     = fifo_mode ? (!buf_empty && (level >= irq_level)) : !buf_empty;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_mode,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic [2:0]    rd_err,
    input logic          data_ready,
    input logic          overrun,
    input logic          rx_irq,
    input logic          fsm_push,
    input logic          buf_full,
    input logic [LW-1:0] level
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_push && buf_full && $stable(fifo_mode)) |=> overrun); // R7

    AST_BRK_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_err[2]) |-> (rd_err[1] && !rd_err[0] && rd_data == 8'h00)); // R5

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && $stable(fifo_mode)) |-> (level <= 1)); // R8

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L); // R6

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !data_ready && !fsm_push && $stable(fifo_mode)) |=> !data_ready); // R12

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> !rx_irq); // R10
endmodule

bind async_rx async_rx_chk #(.DEPTH(DEPTH), .LW(LW)) i_async_rx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .data_ready(data_ready),
    .overrun   (overrun),
    .rx_irq    (rx_irq),
    .fsm_push  (fsm_push),
    .buf_full  (buf_full),
    .level     (level)
);

// File: tb/test_async_rx.sv
`timescale 1ns/1ps
module test_async_rx;
    localparam int DEPTH = 16;
    localparam int LW    = 5;
    localparam int BITC  = 48;  // 16 ticks x 3 clocks

    typedef struct {
        logic [7:0] d;
        logic [2:0] e;
        string      req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick16 = 1'b0;
    logic          rxd = 1'b1;
    logic [1:0]    char_len = 2'd3;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          fifo_mode = 1'b1;
    logic [LW-1:0] irq_level = 5'd1;
    logic          mon_rd = 1'b0;
    logic          man_rd = 1'b0;
    logic          rd_en;
    logic [7:0]    rd_data;
    logic [2:0]    rd_err;
    logic          data_ready, overrun, rx_irq;

    int   total = 0;
    int   bad = 0;
    int   tdiv = 0;
    bit   auto_pop = 1'b0;
    exp_t q[$];

    assign rd_en = mon_rd | man_rd;

    always #4 clk = ~clk;

    async_rx #(.DEPTH(DEPTH), .TICKS(16), .LW(LW)) i_async_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .fifo_mode(fifo_mode), .irq_level(irq_level), .rd_en(rd_en),
        .rd_data(rd_data), .rd_err(rd_err), .data_ready(data_ready),
        .overrun(overrun), .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        if (tdiv == 2) begin tdiv <= 0; tick16 <= 1'b1; end
        else begin tdiv <= tdiv + 1; tick16 <= 1'b0; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops and compares against the scoreboard queue
    always @(negedge clk) begin
        mon_rd <= 1'b0;
        if (auto_pop && data_ready && !mon_rd) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4 unexpected entry", {21'd0, rd_err, rd_data}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rd_data == e.d && rd_err == e.e, e.req,
                    {21'd0, rd_err, rd_data}, {21'd0, e.e, e.d});
            end
            mon_rd <= 1'b1;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: queues the expected entry, then drives the frame
    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                             input bit store, input string req);
        int nb;
        logic [7:0] m;
        logic pb;
        exp_t e;
        nb = int'(char_len) + 5;
        m  = d & 8'((1 << nb) - 1);
        pb = (^m) ^ par_odd ^ bad_par;
        if (store) begin
            e.d = m; e.e = {1'b0, bad_stop, bad_par & par_en}; e.req = req;
            q.push_back(e);
        end
        rxd = 1'b0; wait_clk(BITC);
        for (int i = 0; i < nb; i++) begin rxd = m[i]; wait_clk(BITC); end
        if (par_en) begin rxd = pb; wait_clk(BITC); end
        if (bad_stop) begin rxd = 1'b0; wait_clk(30); end
        rxd = 1'b1; wait_clk(BITC);
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while ((q.size() != 0 || data_ready) && n < 4000) begin wait_clk(1); n++; end
        wait_clk(4);
        chk(q.size() == 0 && !data_ready, req, q.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t e;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R11 reset state
        chk(!data_ready, "R11 data_ready", data_ready, 0);
        chk(!overrun, "R11 overrun", overrun, 0);
        chk(!rx_irq, "R11 rx_irq", rx_irq, 0);
        wait_clk(BITC);

        // R1 / R3: 8-bit back-to-back frames, single stop bit
        auto_pop = 1'b1;
        send_char(8'hA5, 0, 0, 1, "R1 8-bit A5");
        send_char(8'h3C, 0, 0, 1, "R3 back-to-back 3C");
        send_char(8'hFF, 0, 0, 1, "R3 back-to-back FF");
        drain("R1 drain");

        // R1: short characters, upper bits zero
        char_len = 2'd0; send_char(8'hFF, 0, 0, 1, "R1 5-bit"); drain("R1 drain5");
        char_len = 2'd1; send_char(8'hC3, 0, 0, 1, "R1 6-bit"); drain("R1 drain6");
        char_len = 2'd2; send_char(8'h81, 0, 0, 1, "R1 7-bit"); drain("R1 drain7");
        char_len = 2'd3;

        // R2: parity even and odd
        par_en = 1'b1; par_odd = 1'b0;
        send_char(8'h5A, 0, 0, 1, "R2 even ok");
        send_char(8'h5A, 1, 0, 1, "R2 even bad");
        par_odd = 1'b1;
        send_char(8'h13, 0, 0, 1, "R2 odd ok");
        send_char(8'h13, 1, 0, 1, "R2 odd bad");
        drain("R2 drain");

        // R3: framing error on first stop bit
        par_en = 1'b0;
        send_char(8'h44, 0, 1, 1, "R3 framing");
        send_char(8'h00, 0, 0, 1, "R3 zero data good stop");
        drain("R3 drain");

        // R4: start pulse too short
        rxd = 1'b0; wait_clk(12); rxd = 1'b1;
        wait_clk(10 * BITC);
        chk(!data_ready && q.size() == 0, "R4 glitch", data_ready, 0);
        send_char(8'h77, 0, 0, 1, "R4 after glitch");
        drain("R4 drain");

        // R5: break with odd parity on
        par_en = 1'b1; par_odd = 1'b1;
        e.d = 8'h00; e.e = 3'b110; e.req = "R5 break tag"; q.push_back(e);
        rxd = 1'b0; wait_clk(16 * BITC); rxd = 1'b1; wait_clk(2 * BITC);
        send_char(8'h21, 0, 0, 1, "R5 after break");
        drain("R5 drain");

        // R6 / R7 / R10: fill the buffer
        par_en = 1'b0; auto_pop = 1'b0; irq_level = 5'd4;
        for (int i = 0; i < 3; i++) send_char(8'(8'h30 + i), 0, 0, 1, "R6 order");
        chk(!rx_irq, "R10 below level", rx_irq, 0);
        send_char(8'h33, 0, 1, 1, "R6 tag per entry");
        chk(rx_irq, "R10 at level", rx_irq, 1);
        for (int i = 4; i < 16; i++) send_char(8'(8'h30 + i), 0, 0, 1, "R6 order");
        chk(!overrun, "R7 no overrun at 16", overrun, 0);
        send_char(8'hEE, 0, 0, 0, "R7 dropped");
        chk(overrun, "R7 overrun set", overrun, 1);
        auto_pop = 1'b1;
        drain("R6 drain");
        chk(!overrun, "R7 cleared by pop", overrun, 0);
        irq_level = 5'd1;

        // R8 / R10: single holding register
        fifo_mode = 1'b0; auto_pop = 1'b0; wait_clk(4);
        send_char(8'h11, 0, 0, 1, "R8 kept");
        send_char(8'h22, 0, 0, 0, "R8 dropped");
        chk(overrun, "R8 overrun", overrun, 1);
        chk(rx_irq, "R10 non-buffer irq", rx_irq, 1);
        auto_pop = 1'b1;
        drain("R8 drain");

        // R9: mode change flushes
        auto_pop = 1'b0;
        send_char(8'h33, 0, 0, 0, "R9 flushed");
        chk(data_ready, "R9 held", data_ready, 1);
        fifo_mode = 1'b1; wait_clk(3);
        chk(!data_ready, "R9 flush", data_ready, 0);

        // R12: pop on empty
        man_rd = 1'b1; wait_clk(3); man_rd = 1'b0; wait_clk(2);
        chk(!data_ready && !overrun, "R12 empty pop", {data_ready, overrun}, 0);
        auto_pop = 1'b1;
        send_char(8'h5C, 0, 0, 1, "R12 next char intact");
        drain("R12 drain");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule